// File: doc/BRIEF.md
# Smart Card Supply Request and Card Clock Controller

This block is the digital host-side controller of a smart card interface. It watches an active-low activate command and a supply-select line and picks one of three card supply levels. A low select line at activation requests 3 V. A high select line requests 5 V, unless the line falls within a short window after activation, in which case it requests 1.8 V. Activation proceeds only while a debounced card is present and no fault is latched. Once a level is chosen, the select line has no further effect until the command is released.

Card insertion is debounced over a parameterised number of cycles. Removal acts at once and cuts an active supply. An active-low level interrupt reports a missing card or a latched fault. The block also produces the card clock from the system clock. A two-bit code picks the ratio, and a new ratio is taken up only when the card clock falls, so no shortened high pulse can appear. The select synchroniser resets high, which matches the 5 V default of an unconnected select pin. All control pins are plain levels and carry no handshake.

Top module: `card_act_ctrl`

## Requirements
- R1: With the select line high when the activate command falls, and still high for WIN_CYC cycles, `supply_req` becomes 2'b10 (5 V) WIN_CYC+3 cycles after the command falls. The encoding is 00 off, 01 3 V, 10 5 V, 11 1.8 V.
- R2: With the select line low when the activate command falls, `supply_req` becomes 2'b01 (3 V) 3 cycles later.
- R3: If the select line falls d cycles after the command, with 1 <= d <= WIN_CYC, `supply_req` becomes 2'b11 (1.8 V) d+3 cycles after the command. With d = WIN_CYC+1 the result is 5 V.
- R4: Once a level is chosen, changes on the select line leave `supply_req` unchanged.
- R5: Raising the activate command returns `supply_req` to 2'b00 3 cycles later and readies the block for a new selection.
- R6: No level is requested while no debounced card is present. A command that went low without a card is held off until it is raised, even if a card arrives meanwhile.
- R7: The card counts as present only after `pres` has been high for DEB_CYC consecutive cycles. `irq_n` rises DEB_CYC+2 cycles after `pres` rises, and a shorter pulse is ignored.
- R8: A card removal drives `irq_n` low 3 cycles after `pres` falls, with no debounce. It also turns an active supply off 4 cycles after `pres` falls.
- R9: `irq_n` is low while no card is present or a fault is latched. A high `fault` turns the supply off and latches the fault 1 cycle later. The latch clears once the command is high and `fault` is low.
- R10: `card_clk` has equal high and low phases of N system cycles each. The select codes map 00 to N=4, 01 to N=1, 10 to N=8 and 11 to N=2. Reset starts at N=4 with the clock low.
- R11: A ratio change made during a high phase lets that phase finish at the old length, and the new ratio starts with the next low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_n | input | 1 | Activate command, active low, asynchronous |
| vsel | input | 1 | Supply select line, asynchronous |
| pres | input | 1 | Raw card-presence level, active high, asynchronous |
| fault | input | 1 | Fault indication, synchronous to clk, active high |
| clk_sel | input | 2 | Card clock ratio code |
| supply_req | output | 2 | Requested card supply: 00 off, 01 3 V, 10 5 V, 11 1.8 V |
| irq_n | output | 1 | Active-low interrupt: card absent or fault latched |
| card_clk | output | 1 | Divided card clock |

## Verification
Each result has a fixed due cycle counted from the stimulus edge. Activation to 3 V and deactivation take 3 cycles. 5 V takes WIN_CYC+3 cycles, and 1.8 V takes d+3 cycles after the command. Removal shows on the interrupt after 3 cycles and on the supply after 4. A fault acts after 1 cycle, and insertion is seen after DEB_CYC+2 cycles. The driver stamps each expected supply value with its due cycle and queues it. The monitor samples on the falling clock edge and matches every change of `supply_req` against the head of the queue for both value and cycle, so an early, late or unexpected change is reported. Interrupt and card-clock phase lengths are checked at exact negedge-sample counts.

// File: rtl/cact_pkg.sv
package cact_pkg;

  typedef enum logic [1:0] {
    SUP_OFF = 2'b00,
    SUP_3V  = 2'b01,
    SUP_5V  = 2'b10,
    SUP_1V8 = 2'b11
  } supply_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WIN,
    ST_ON,
    ST_HOLD
  } act_st_e;

  // half-period length minus one for each ratio code
  function automatic logic [2:0] half_lim(input logic [1:0] code);
    case (code)
      2'b00:   half_lim = 3'd3;
      2'b01:   half_lim = 3'd0;
      2'b10:   half_lim = 3'd7;
      default: half_lim = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/cact_sync.sv
module cact_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        q[i] <= RST_VAL[i];
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/cact_debounce.sv
module cact_debounce #(
  parameter int DEB_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_s,
  output logic present
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      present <= 1'b0;
    end else if (!raw_s) begin
      cnt     <= '0;
      present <= 1'b0;
    end else if (!present) begin
      if (cnt == LAST) begin
        present <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cact_fsm.sv
module cact_fsm
  import cact_pkg::*;
#(
  parameter int WIN_CYC = 40
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    act_s,
  input  logic    vsel_s,
  input  logic    present,
  input  logic    fault,
  output supply_e supply,
  output logic    flt_lat
);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN_CYC - 1);

  act_st_e       st;
  logic [WW-1:0] wcnt;
  logic          stop;

  assign stop = fault || !present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      supply  <= SUP_OFF;
      wcnt    <= '0;
      flt_lat <= 1'b0;
    end else begin
      if (fault)      flt_lat <= 1'b1;
      else if (act_s) flt_lat <= 1'b0;

      case (st)
        ST_IDLE: if (!act_s) begin
          if (stop || flt_lat) st <= ST_HOLD;
          else if (!vsel_s) begin
            st     <= ST_ON;
            supply <= SUP_3V;
          end else begin
            st   <= ST_WIN;
            wcnt <= '0;
          end
        end
        ST_WIN: begin
          if (act_s)      st <= ST_IDLE;
          else if (stop)  st <= ST_HOLD;
          else if (!vsel_s) begin
            st     <= ST_ON;
            supply <= SUP_1V8;
          end else if (wcnt == WLAST) begin
            st     <= ST_ON;
            supply <= SUP_5V;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_ON: begin
          if (act_s) begin
            st     <= ST_IDLE;
            supply <= SUP_OFF;
          end else if (stop) begin
            st     <= ST_HOLD;
            supply <= SUP_OFF;
          end
        end
        default: if (act_s) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cact_clkdiv.sv
module cact_clkdiv
  import cact_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       cclk
);
  logic [2:0] cnt;
  logic [2:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      lim  <= 3'd3;
      cclk <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      cclk <= ~cclk;
      if (cclk) lim <= half_lim(sel);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_act_ctrl.sv
module card_act_ctrl
  import cact_pkg::*;
#(
  parameter int WIN_CYC = 40,
  parameter int DEB_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_n,
  input  logic       vsel,
  input  logic       pres,
  input  logic       fault,
  input  logic [1:0] clk_sel,
  output logic [1:0] supply_req,
  output logic       irq_n,
  output logic       card_clk
);
  logic [2:0] raw_s;
  logic       present;
  logic       flt_lat;
  supply_e    supply;

  // bit0 activate (idle high), bit1 select (defaults high), bit2 presence
  cact_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pres, vsel, act_n}), .q(raw_s)
  );

  cact_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw_s(raw_s[2]), .present(present)
  );

  cact_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .act_s(raw_s[0]), .vsel_s(raw_s[1]),
    .present(present), .fault(fault), .supply(supply), .flt_lat(flt_lat)
  );

  cact_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel), .cclk(card_clk)
  );

  assign supply_req = supply;
  assign irq_n      = present && !flt_lat;
endmodule

// File: rtl/card_act_chk.sv
module card_act_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fault,
  input logic [1:0] supply_req,
  input logic       irq_n
);
  p_fault_cuts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (supply_req == 2'b00));

  p_fault_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !irq_n);

  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_req != 2'b00) |=> (supply_req == 2'b00 || $stable(supply_req)));

  p_off_when_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && $past(!irq_n)) |-> (supply_req == 2'b00));
endmodule

bind card_act_ctrl card_act_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault(fault),
  .supply_req(supply_req), .irq_n(irq_n)
);

// File: tb/tb_card_act_ctrl.sv
module tb_card_act_ctrl;
  localparam int WIN = 6;
  localparam int DEB = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_n = 1'b1;
  logic       vsel = 1'b1;
  logic       pres = 1'b0;
  logic       fault = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic [1:0] supply_req;
  logic       irq_n;
  logic       card_clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {
    logic [1:0] val;
    int         due;
    string      req;
  } exp_t;
  exp_t sb[$];
  logic [1:0] last_sup = 2'b00;

  card_act_ctrl #(.WIN_CYC(WIN), .DEB_CYC(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .act_n(act_n), .vsel(vsel), .pres(pres),
    .fault(fault), .clk_sel(clk_sel), .supply_req(supply_req),
    .irq_n(irq_n), .card_clk(card_clk)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] v, input int dly, input string req);
    exp_t e;
    e.val = v; e.due = cyc + dly; e.req = req;
    sb.push_back(e);
  endtask

  // scoreboard monitor: every change of supply_req must match the queue head
  always @(negedge clk) begin
    if (rst_n && supply_req !== last_sup) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 unexpected change", int'(supply_req), int'(last_sup));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(supply_req === e.val && cyc == e.due, e.req, int'(supply_req), int'(e.val));
        if (cyc != e.due)
          $display("FAIL %s timing: actual cycle %0d expected %0d", e.req, cyc, e.due);
      end
      last_sup = supply_req;
    end
  end

  task automatic wait_rise();
    logic prev;
    prev = card_clk;
    forever begin
      @(negedge clk);
      if (!prev && card_clk) break;
      prev = card_clk;
    end
  endtask

  task automatic run_len(output int n);
    logic lvl;
    lvl = card_clk;
    n = 1;
    forever begin
      @(negedge clk);
      if (card_clk === lvl) n++;
      else break;
    end
  endtask

  task automatic deact();
    act_n = 1'b0 ^ 1'b1;
    push(2'b00, 3, "R5 deactivate");
    step(10);
  endtask

  task automatic sel_fall(input int d, input logic [1:0] v, input int due, input string req);
    act_n = 1'b0;
    push(v, due, req);
    step(d);
    vsel = 1'b0;
    step(WIN + 10);
    vsel = 1'b1;
    deact();
  endtask

  initial begin
    int h;
    int l;
    int ns[4];
    logic [1:0] codes[4];
    ns = '{1, 2, 4, 8};
    codes = '{2'b01, 2'b11, 2'b00, 2'b10};

    step(5);
    rst_n = 1'b1;
    step(1);
    // reset state (R9, R10)
    chk(supply_req == 2'b00, "R9 reset supply", int'(supply_req), 0);
    chk(irq_n == 1'b0, "R9 reset irq without card", int'(irq_n), 0);
    chk(card_clk == 1'b0, "R10 reset clock low", int'(card_clk), 0);

    // R7: short presence pulse ignored
    pres = 1'b1;
    step(DEB / 2);
    pres = 1'b0;
    step(30);
    chk(irq_n == 1'b0, "R7 short pulse ignored", int'(irq_n), 0);

    // R7: full insertion
    pres = 1'b1;
    step(DEB + 1);
    chk(irq_n == 1'b0, "R7 not yet debounced", int'(irq_n), 0);
    step(1);
    chk(irq_n == 1'b1, "R7 debounced insertion", int'(irq_n), 1);
    step(5);

    // R1 then R4
    act_n = 1'b0;
    push(2'b10, WIN + 3, "R1 5V select");
    step(WIN + 10);
    vsel = 1'b0; step(5); vsel = 1'b1; step(5);
    chk(supply_req == 2'b10, "R4 select ignored while on", int'(supply_req), 2);
    deact();

    // R2 then R4
    vsel = 1'b0; step(2);
    act_n = 1'b0;
    push(2'b01, 3, "R2 3V select");
    step(10);
    vsel = 1'b1; step(10);
    chk(supply_req == 2'b01, "R4 select rise ignored", int'(supply_req), 1);
    deact();

    // R3 window corners
    sel_fall(2, 2'b11, 5, "R3 1V8 early fall");
    sel_fall(WIN, 2'b11, WIN + 3, "R3 1V8 last window cycle");
    sel_fall(WIN + 1, 2'b10, WIN + 3, "R3 fall after window gives 5V");

    // R6: command without card is held off, even after insertion
    pres = 1'b0; step(10);
    act_n = 1'b0; step(10);
    chk(supply_req == 2'b00, "R6 no card no supply", int'(supply_req), 0);
    pres = 1'b1; step(DEB + 10);
    chk(irq_n == 1'b1 && supply_req == 2'b00, "R6 held until release", int'(supply_req), 0);
    act_n = 1'b1; step(10);
    vsel = 1'b0;
    act_n = 1'b0;
    push(2'b01, 3, "R6 activation after release");
    step(10);

    // R8: removal while active
    pres = 1'b0;
    push(2'b00, 4, "R8 removal cuts supply");
    step(2);
    chk(irq_n == 1'b1, "R8 irq not before 3 cycles", int'(irq_n), 1);
    step(1);
    chk(irq_n == 1'b0, "R8 irq on removal", int'(irq_n), 0);
    step(10);
    act_n = 1'b1; step(5);
    pres = 1'b1; step(DEB + 10);

    // R9: fault
    act_n = 1'b0;
    push(2'b01, 3, "R9 activate before fault");
    step(10);
    fault = 1'b1;
    push(2'b00, 1, "R9 fault cuts supply");
    step(1);
    chk(irq_n == 1'b0, "R9 fault irq", int'(irq_n), 0);
    fault = 1'b0;
    step(5);
    chk(irq_n == 1'b0, "R9 fault latched", int'(irq_n), 0);
    act_n = 1'b1; vsel = 1'b1;
    step(5);
    chk(irq_n == 1'b1, "R9 fault cleared on release", int'(irq_n), 1);

    // R10: every ratio
    for (int i = 0; i < 4; i++) begin
      clk_sel = codes[i];
      step(40);
      wait_rise();
      run_len(h);
      run_len(l);
      chk(h == ns[i], "R10 high phase", h, ns[i]);
      chk(l == ns[i], "R10 low phase", l, ns[i]);
    end

    // R11: change during high phase
    clk_sel = 2'b10;
    step(40);
    wait_rise();
    clk_sel = 2'b01;
    run_len(h);
    run_len(l);
    chk(h == 8, "R11 high phase completes", h, 8);
    chk(l == 1, "R11 new ratio on low phase", l, 1);
    run_len(h);
    chk(h == 1, "R11 new ratio high phase", h, 1);

    step(5);
    chk(sb.size() == 0, "R5 all expected changes seen", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule